// File: doc/BRIEF.md
# Comparator Interrupt Flag Controller

This block connects the digital outputs of two voltage comparators to the interrupt logic of a small microcontroller. Each comparator output is brought into the clock domain through a two-stage synchroniser. A rising edge of the synchronised output latches a sticky event flag. The CPU sees those flags through a byte-wide register bus. A flag stays set until software writes a one to its dedicated clear bit.

A level interrupt request is raised while any flag is set, comparator interrupts are enabled, and the CPU's global mask input is low. The second comparator also acts as a gated trigger for an external timer's input capture. When that flag goes from clear to set while capture routing is enabled, a one-cycle capture strobe is produced. A capture interrupt request follows the strobe only when the timer's capture interrupt enable and edge-select inputs are both high and the global mask is low.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: A low-to-high change on `cmp_in[i]` sets flag i on the third rising clock edge after the change. `irq_cmp` and `cap_strobe` respond on that same edge.
- R2: A flag is set only by a rising edge of the synchronised comparator output. It stays set while the input remains high. A steady high level does not set it again after it has been cleared.
- R3: `irq_cmp` is high exactly when at least one flag is set, control bit 0 (comparator interrupt enable) is 1, and `cpu_imask` is 0.
- R4: Writing status register address 0x1E with bit 4 = 1 clears flag 0, and with bit 5 = 1 clears flag 1, on the sampling edge. A zero in either bit leaves its flag unchanged.
- R5: If a set event and a clear write hit the same flag on the same edge, the flag ends up set.
- R6: `cap_strobe` is high for exactly one cycle when flag 1 goes from clear to set while control bit 1 (capture routing enable) is 1. No strobe is produced when flag 1 was already set, or when control bit 1 is 0.
- R7: `irq_cap` is high exactly when `cap_strobe` is high, `tmr_icie` and `tmr_iedg` are both 1, and `cpu_imask` is 0.
- R8: Control register address 0x1D reads back bit 0 and bit 1 as written, with the other bits 0. Status address 0x1E reads flag 0 on bit 0 and flag 1 on bit 1, with bits 4 and 5 (and all others) reading 0. Any other address reads 0.
- R9: Reset clears both flags and both control bits, so every output is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmp_in | input | 2 | Asynchronous comparator outputs, 1 = positive input above negative |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cpu_imask | input | 1 | Global interrupt mask; 1 blocks both requests |
| tmr_icie | input | 1 | Timer capture interrupt enable |
| tmr_iedg | input | 1 | Timer capture edge select |
| irq_cmp | output | 1 | Comparator interrupt request (level) |
| cap_strobe | output | 1 | One-cycle timer input-capture trigger |
| irq_cap | output | 1 | Capture-driven interrupt request |

## Verification
A comparator rising edge driven just after edge k must show up in the flags, in `irq_cmp` and in `cap_strobe` after edge k+3, and nowhere earlier. The strobe must be low again after edge k+4. Register writes take effect on the edge that samples `bus_wr`. Read data and both interrupt requests follow register and mask state combinationally. The bench keys every expected output to an absolute cycle index counted in rising edges. It samples 1 ns after the matching edge. Register reads are checked half a nanosecond after the address is set, in the quiet half of the cycle.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;

  localparam int unsigned REG_W          = 8;
  localparam int unsigned CTRL_IE_BIT    = 0;
  localparam int unsigned CTRL_CAPEN_BIT = 1;
  localparam int unsigned STAT_FLAG_LSB  = 0;
  localparam int unsigned STAT_CLR_LSB   = 4;

  // sticky flag update: a set event outranks a clear request
  function automatic logic flag_next(logic cur, logic set_e, logic clr_e);
    return set_e | (cur & ~clr_e);
  endfunction

  function automatic logic cmp_irq_level(logic any_flag, logic ie, logic mask);
    return any_flag & ie & ~mask;
  endfunction

  function automatic logic cap_irq_level(logic strobe, logic icie, logic iedg, logic mask);
    return strobe & icie & iedg & ~mask;
  endfunction

endpackage

// File: rtl/cmp_edge_sync.sv
module cmp_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/cmp_flag_cell.sv
module cmp_flag_cell
  import cmp_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_next(flag, set_evt, clr_req);
  end
endmodule

// File: rtl/cmp_regs.sv
module cmp_regs
  import cmp_irq_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 8,
  parameter int unsigned          NCMP      = 2,
  parameter logic [ADDR_W-1:0]    CTRL_ADDR = 'h1D,
  parameter logic [ADDR_W-1:0]    STAT_ADDR = 'h1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [NCMP-1:0]   flags,
  output logic              ctrl_ie,
  output logic              ctrl_capen,
  output logic [NCMP-1:0]   clr_req,
  output logic [REG_W-1:0]  bus_rdata
);
  logic ctrl_sel, stat_sel;
  logic unused_wbits;

  assign ctrl_sel     = (bus_addr == CTRL_ADDR);
  assign stat_sel     = (bus_addr == STAT_ADDR);
  assign unused_wbits = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_ie    <= 1'b0;
      ctrl_capen <= 1'b0;
    end else if (bus_wr && ctrl_sel) begin
      ctrl_ie    <= bus_wdata[CTRL_IE_BIT];
      ctrl_capen <= bus_wdata[CTRL_CAPEN_BIT];
    end
  end

  assign clr_req = (bus_wr && stat_sel) ? bus_wdata[STAT_CLR_LSB +: NCMP] : '0;

  always_comb begin
    bus_rdata = '0;
    if (ctrl_sel) begin
      bus_rdata[CTRL_IE_BIT]    = ctrl_ie;
      bus_rdata[CTRL_CAPEN_BIT] = ctrl_capen;
    end else if (stat_sel) begin
      bus_rdata[STAT_FLAG_LSB +: NCMP] = flags;
    end
  end
endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
  import cmp_irq_pkg::*;
#(
  parameter int unsigned       NCMP        = 2,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       CAP_SRC     = 1,
  parameter int unsigned       ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 'h1D,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 'h1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCMP-1:0]   cmp_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              cpu_imask,
  input  logic              tmr_icie,
  input  logic              tmr_iedg,
  output logic              irq_cmp,
  output logic              cap_strobe,
  output logic              irq_cap
);
  // named internal events, also observed by the bound checker
  logic [NCMP-1:0] set_evt;
  logic [NCMP-1:0] clr_req;
  logic [NCMP-1:0] flags;
  logic            ctrl_ie;
  logic            ctrl_capen;
  logic            cap_fire;

  for (genvar i = 0; i < NCMP; i++) begin : g_chan
    cmp_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (cmp_in[i]),
      .rise (set_evt[i])
    );
    cmp_flag_cell flag_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_evt(set_evt[i]),
      .clr_req(clr_req[i]),
      .flag   (flags[i])
    );
  end

  cmp_regs #(
    .ADDR_W   (ADDR_W),
    .NCMP     (NCMP),
    .CTRL_ADDR(CTRL_ADDR),
    .STAT_ADDR(STAT_ADDR)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .flags     (flags),
    .ctrl_ie   (ctrl_ie),
    .ctrl_capen(ctrl_capen),
    .clr_req   (clr_req),
    .bus_rdata (bus_rdata)
  );

  // capture fires only on a clear-to-set transition of the capture source flag
  assign cap_fire = ctrl_capen & set_evt[CAP_SRC] & ~flags[CAP_SRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_strobe <= 1'b0;
    else        cap_strobe <= cap_fire;
  end

  assign irq_cmp = cmp_irq_level(|flags, ctrl_ie, cpu_imask);
  assign irq_cap = cap_irq_level(cap_strobe, tmr_icie, tmr_iedg, cpu_imask);
endmodule

// File: rtl/cmp_irq_chk.sv
module cmp_irq_chk #(
  parameter int unsigned NCMP    = 2,
  parameter int unsigned CAP_SRC = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCMP-1:0] set_evt,
  input logic [NCMP-1:0] clr_req,
  input logic [NCMP-1:0] flags,
  input logic            ctrl_ie,
  input logic            ctrl_capen,
  input logic            cpu_imask,
  input logic            tmr_icie,
  input logic            tmr_iedg,
  input logic            irq_cmp,
  input logic            cap_strobe,
  input logic            irq_cap
);
  for (genvar i = 0; i < NCMP; i++) begin : g_flag
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> flags[i]);
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req[i] && !set_evt[i]) |=> !flags[i]);
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr_req[i]) |=> flags[i]);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[i] && !set_evt[i]) |=> !flags[i]);
  end

  p_irq_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_imask |-> (!irq_cmp && !irq_cap));
  p_irq_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmp |-> (ctrl_ie && (flags != '0)));
  p_strobe_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |=> !cap_strobe);
  p_strobe_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |-> (flags[CAP_SRC] && !$past(flags[CAP_SRC]) && $past(ctrl_capen)));
  p_cap_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cap |-> (cap_strobe && tmr_icie && tmr_iedg));
endmodule

bind cmp_irq_ctrl cmp_irq_chk #(.NCMP(NCMP), .CAP_SRC(CAP_SRC)) chk_i (.*);

// File: tb/cmp_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module cmp_irq_ctrl_tb_top;
  localparam logic [7:0] A_CTRL = 8'h1D;
  localparam logic [7:0] A_STAT = 8'h1E;
  localparam int S_IRQ = 0, S_CAP = 1, S_ICAP = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cmp_in;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic       bus_wr, cpu_imask, tmr_icie, tmr_iedg;
  logic       irq_cmp, cap_strobe, irq_cap;

  always #2.5 clk = ~clk;

  cmp_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_imask(cpu_imask), .tmr_icie(tmr_icie), .tmr_iedg(tmr_iedg),
    .irq_cmp(irq_cmp), .cap_strobe(cap_strobe), .irq_cap(irq_cap)
  );

  typedef struct {
    int    due;
    int    sel;
    logic  exp;
    string req;
  } item_t;

  item_t sbq[$];
  int    cyc = 0;
  int    n_run = 0, n_fail = 0;
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic probe(int sel);
    case (sel)
      S_IRQ:   return irq_cmp;
      S_CAP:   return cap_strobe;
      default: return irq_cap;
    endcase
  endfunction

  function automatic string sname(int sel);
    case (sel)
      S_IRQ:   return "irq_cmp";
      S_CAP:   return "cap_strobe";
      default: return "irq_cap";
    endcase
  endfunction

  // monitor: compares due scoreboard items 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].due == cyc) begin
        n_run++;
        if (probe(sbq[i].sel) !== sbq[i].exp) begin
          n_fail++;
          $display("FAIL %s cycle %0d %s: actual=%b expected=%b",
                   sbq[i].req, cyc, sname(sbq[i].sel), probe(sbq[i].sel), sbq[i].exp);
        end
        sbq.delete(i);
      end
    end
  end

  task automatic expect_at(int sel, logic v, int dly, string req);
    item_t it;
    it.due = cyc + dly; it.sel = sel; it.exp = v; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string req);
    bus_addr = a;
    #0.5;
    n_run++;
    if (bus_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s read addr %h: actual=%h expected=%h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // drop a comparator, let the low level settle, then raise it
  task automatic raise_cmp(int idx);
    cmp_in[idx] = 1'b0;
    step(4);
    cmp_in[idx] = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; cmp_in = 2'b00; bus_addr = 8'h00; bus_wdata = 8'h00; bus_wr = 1'b0;
    cpu_imask = 1'b0; tmr_icie = 1'b0; tmr_iedg = 1'b0;
    step(3);
    rst_n = 1'b1;

    // R9: reset state
    rd(A_CTRL, 8'h00, "R9");
    rd(A_STAT, 8'h00, "R9");
    expect_at(S_IRQ, 1'b0, 1, "R9");
    expect_at(S_CAP, 1'b0, 1, "R9");
    step(2);

    // R8: control readback, unmapped address
    wr(A_CTRL, 8'hFD);
    rd(A_CTRL, 8'h01, "R8");
    rd(8'h00, 8'h00, "R8");
    wr(A_CTRL, 8'h01);

    // R1, R3: latency of flag 0 into irq_cmp
    cmp_in[0] = 1'b1;
    expect_at(S_IRQ, 1'b0, 2, "R1");
    expect_at(S_IRQ, 1'b1, 3, "R1");
    step(5);
    rd(A_STAT, 8'h01, "R2");

    // R4: zero and wrong-bit writes leave flag 0 alone, bit 4 clears it
    wr(A_STAT, 8'h00);
    rd(A_STAT, 8'h01, "R4");
    wr(A_STAT, 8'h20);
    rd(A_STAT, 8'h01, "R4");
    wr(A_STAT, 8'h10);
    rd(A_STAT, 8'h00, "R4");
    expect_at(S_IRQ, 1'b0, 1, "R4");
    step(6);
    rd(A_STAT, 8'h00, "R2");   // steady high, no retrigger

    // R3: global mask blocks the request, release restores it
    cpu_imask = 1'b1;
    raise_cmp(0);
    expect_at(S_IRQ, 1'b0, 3, "R3");
    expect_at(S_IRQ, 1'b0, 4, "R3");
    step(5);
    rd(A_STAT, 8'h01, "R2");
    cpu_imask = 1'b0;
    expect_at(S_IRQ, 1'b1, 1, "R3");
    step(2);
    wr(A_CTRL, 8'h00);
    expect_at(S_IRQ, 1'b0, 1, "R3");
    step(2);
    wr(A_CTRL, 8'h01);
    expect_at(S_IRQ, 1'b1, 1, "R3");
    step(2);

    // R5: set event and clear write on the same edge
    raise_cmp(0);
    step(2);
    wr(A_STAT, 8'h10);
    rd(A_STAT, 8'h01, "R5");
    expect_at(S_IRQ, 1'b1, 1, "R5");
    step(2);
    wr(A_STAT, 8'h10);
    rd(A_STAT, 8'h00, "R4");

    // R6, R7: capture path fully enabled
    tmr_icie = 1'b1; tmr_iedg = 1'b1;
    wr(A_CTRL, 8'h03);
    raise_cmp(1);
    expect_at(S_CAP,  1'b0, 2, "R6");
    expect_at(S_CAP,  1'b1, 3, "R6");
    expect_at(S_CAP,  1'b0, 4, "R6");
    expect_at(S_ICAP, 1'b1, 3, "R7");
    expect_at(S_ICAP, 1'b0, 4, "R7");
    expect_at(S_IRQ,  1'b1, 3, "R1");
    step(6);
    rd(A_STAT, 8'h02, "R1");

    // R6: flag 1 already set, no strobe
    raise_cmp(1);
    expect_at(S_CAP, 1'b0, 3, "R6");
    expect_at(S_CAP, 1'b0, 4, "R6");
    step(6);

    // R6: routing disabled, no strobe but flag still sets
    wr(A_STAT, 8'h20);
    wr(A_CTRL, 8'h01);
    raise_cmp(1);
    expect_at(S_CAP, 1'b0, 3, "R6");
    step(6);
    rd(A_STAT, 8'h02, "R6");

    // R7: each gate on the capture interrupt
    wr(A_CTRL, 8'h03);
    wr(A_STAT, 8'h20);
    tmr_icie = 1'b0;
    raise_cmp(1);
    expect_at(S_CAP,  1'b1, 3, "R7");
    expect_at(S_ICAP, 1'b0, 3, "R7");
    step(6);
    wr(A_STAT, 8'h20);
    tmr_icie = 1'b1; tmr_iedg = 1'b0;
    raise_cmp(1);
    expect_at(S_CAP,  1'b1, 3, "R7");
    expect_at(S_ICAP, 1'b0, 3, "R7");
    step(6);
    wr(A_STAT, 8'h20);
    tmr_iedg = 1'b1; cpu_imask = 1'b1;
    raise_cmp(1);
    expect_at(S_CAP,  1'b1, 3, "R7");
    expect_at(S_ICAP, 1'b0, 3, "R7");
    step(6);
    cpu_imask = 1'b0;

    // R8: both flags visible, clear bits read zero
    raise_cmp(0);
    step(6);
    rd(A_STAT, 8'h03, "R8");
    wr(A_STAT, 8'h30);
    rd(A_STAT, 8'h00, "R4");

    step(8);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule